// File: doc/BRIEF.md
# Predicated Byte-Enable Writeback Unit

This block sits between a 64-bit SIMD result and a register file that has one write strobe per byte. It takes a result word, a per-element predicate, an element-width code, an inversion flag and a mode bit. From these it builds the write data and eight byte strobes. Masked-out elements are then handled in one write cycle, and the destination is never read first.

In merge mode, the byte strobes come from the predicate, so bytes of masked-out elements keep their old value. In zero-fill mode, every byte is strobed and masked-out bytes are written as zero. A single flag flips the sense of the predicate, so no separate instruction is needed to complement the mask. A 32-entry, 64-bit register file with byte strobes is included so the stored effect of each write can be seen on a combinational read port.

Top module: `pred_wb_unit`

## Requirements
- R1: The width code `ew_sel` selects element size: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = 64-bit. Byte lane b belongs to element b / 2^ew_sel and takes that element's predicate bit, `pred[b >> ew_sel]`. Every byte of one element therefore gets the same lane-mask bit.
- R2: When `pred_inv` is 1, each effective predicate bit is the complement of the selected `pred` bit.
- R3: In merge mode (`zero_mode`=0) with `wr_valid`=1, `byte_we` equals the lane mask and `wr_data` equals `result`. Bytes whose strobe is low keep their previous register contents.
- R4: In zero-fill mode (`zero_mode`=1) with `wr_valid`=1, all eight `byte_we` bits are 1. Bytes of `wr_data` whose lane-mask bit is 0 are zero, and the other bytes equal `result`.
- R5: When `wr_valid`=0, `byte_we` is 0 in both modes and no register entry changes.
- R6: Predicate bits above the element count for the selected width have no effect. For example, at 64-bit width only `pred[0]` matters.
- R7: The register file holds 32 entries of 64 bits, and every entry reads zero after reset. On each rising clock edge it writes the bytes whose strobe is set into entry `wr_addr`. `rd_data` shows entry `rd_addr` combinationally, so a write is visible right after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_valid | input | 1 | Global write qualifier |
| wr_addr | input | 5 | Destination entry |
| result | input | 64 | SIMD execution result |
| pred | input | 8 | Per-element predicate bits, element i uses bit i |
| ew_sel | input | 2 | Element width code |
| pred_inv | input | 1 | Complement the predicate |
| zero_mode | input | 1 | 1 = zero-fill masked elements, 0 = merge |
| rd_addr | input | 5 | Read entry select |
| rd_data | output | 64 | Combinational read of the selected entry |
| wr_data | output | 64 | Data presented to the register file |
| byte_we | output | 8 | Byte write strobes presented to the register file |

## Verification
The hardest case to reach from the ports is the one merge mode exists for: a destination byte that already holds a known non-zero value and is then skipped by a partially masked write. The bench first fills each target entry with a full write of a distinctive pattern. It then overwrites the entry with a different result under mixed predicates at each width, with and without inversion. Every read-back byte must then be either the new result byte or the earlier pattern, so a strobe that is high when it should be low shows up immediately.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  localparam int unsigned XLEN    = 64;
  localparam int unsigned NBYTES  = XLEN / 8;
  localparam int unsigned BIDX_W  = $clog2(NBYTES);
  localparam int unsigned EW_W    = 2;

  typedef enum logic [EW_W-1:0] {
    EW_B8  = 2'b00,
    EW_B16 = 2'b01,
    EW_B32 = 2'b10,
    EW_B64 = 2'b11
  } elem_width_e;
endpackage

// File: rtl/pwu_rst_sync.sv
module pwu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwu_lane_mask.sv
module pwu_lane_mask
  import pwu_pkg::*;
#(
  parameter int unsigned NB = NBYTES
) (
  input  logic [EW_W-1:0] ew_sel,
  input  logic [NB-1:0]   pred,
  input  logic            pred_inv,
  output logic [NB-1:0]   lane_mask
);
  localparam int unsigned IW = $clog2(NB);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [IW-1:0] elem_idx;
    always_comb begin
      elem_idx     = IW'(b) >> ew_sel;
      lane_mask[b] = pred[elem_idx] ^ pred_inv;
    end
  end
endmodule

// File: rtl/pwu_wb_former.sv
module pwu_wb_former
  import pwu_pkg::*;
#(
  parameter int unsigned NB = NBYTES
) (
  input  logic            wr_valid,
  input  logic            zero_mode,
  input  logic [NB-1:0]   lane_mask,
  input  logic [NB*8-1:0] result,
  output logic [NB*8-1:0] wr_data,
  output logic [NB-1:0]   byte_we
);
  logic [NB-1:0] strobe_src;

  always_comb begin
    strobe_src = zero_mode ? {NB{1'b1}} : lane_mask;
    byte_we    = strobe_src & {NB{wr_valid}};
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_comb begin
      if (zero_mode && !lane_mask[b]) wr_data[b*8 +: 8] = 8'h00;
      else                            wr_data[b*8 +: 8] = result[b*8 +: 8];
    end
  end
endmodule

// File: rtl/pwu_regfile.sv
module pwu_regfile #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NB    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [NB-1:0]            byte_we,
  input  logic [NB*8-1:0]          wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [NB*8-1:0]          rd_data
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned DW = NB * 8;

  logic [DEPTH-1:0][DW-1:0] rows;

  for (genvar e = 0; e < DEPTH; e++) begin : g_row
    logic          hit;
    logic [NB-1:0] row_en;
    logic [DW-1:0] row_q;
    logic [DW-1:0] row_d;

    always_comb begin
      hit    = (wr_addr == AW'(e));
      row_en = byte_we & {NB{hit}};
      row_d  = row_q;
      for (int b = 0; b < NB; b++) begin
        if (row_en[b]) row_d[b*8 +: 8] = wr_data[b*8 +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (|row_en) row_q <= row_d;
    end

    assign rows[e] = row_q;
  end

  assign rd_data = rows[rd_addr];

  for (genvar b = 0; b < NB; b++) begin : g_chk
    // R7
    wr_byte_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_we[b] && wr_addr == rd_addr) |=>
        (rd_addr != $past(rd_addr)) || (rd_data[b*8 +: 8] == $past(wr_data[b*8 +: 8])));
    // R3
    masked_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_we[b] && wr_addr == rd_addr) |=>
        (rd_addr != $past(rd_addr)) || (rd_data[b*8 +: 8] == $past(rd_data[b*8 +: 8])));
  end
endmodule

// File: rtl/pred_wb_unit.sv
module pred_wb_unit
  import pwu_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [XLEN-1:0]          result,
  input  logic [NBYTES-1:0]        pred,
  input  logic [EW_W-1:0]          ew_sel,
  input  logic                     pred_inv,
  input  logic                     zero_mode,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [XLEN-1:0]          rd_data,
  output logic [XLEN-1:0]          wr_data,
  output logic [NBYTES-1:0]        byte_we
);
  logic              srst_n;
  logic              wr_valid_g;
  logic [NBYTES-1:0] lane_mask;

  pwu_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // writes are held off until the synchronised reset is released
  assign wr_valid_g = wr_valid & srst_n;

  pwu_lane_mask #(.NB(NBYTES)) u_mask (
    .ew_sel    (ew_sel),
    .pred      (pred),
    .pred_inv  (pred_inv),
    .lane_mask (lane_mask)
  );

  pwu_wb_former #(.NB(NBYTES)) u_form (
    .wr_valid  (wr_valid_g),
    .zero_mode (zero_mode),
    .lane_mask (lane_mask),
    .result    (result),
    .wr_data   (wr_data),
    .byte_we   (byte_we)
  );

  pwu_regfile #(.DEPTH(DEPTH), .NB(NBYTES)) u_rf (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_addr (wr_addr),
    .byte_we (byte_we),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R5
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_valid |-> (byte_we == '0));
  // R4
  zero_fill_all_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_valid && zero_mode) |-> (byte_we == '1));
  // R4
  zero_fill_b0_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (zero_mode && ew_sel == EW_B8 && (pred[0] == pred_inv)) |-> (wr_data[7:0] == 8'h00));
  // R1
  whole_elem_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ew_sel == EW_B64 && !zero_mode && wr_valid) |-> (byte_we == '0 || byte_we == '1));
  // R3
  merge_pass_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !zero_mode |-> (wr_data == result));
endmodule

// File: tb/tb_pred_wb_unit.sv
`timescale 1ns/1ps
module tb_pred_wb_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [4:0]  wr_addr;
  logic [63:0] result;
  logic [7:0]  pred;
  logic [1:0]  ew_sel;
  logic        pred_inv;
  logic        zero_mode;
  logic [4:0]  rd_addr;
  logic [63:0] rd_data;
  logic [63:0] wr_data;
  logic [7:0]  byte_we;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [63:0] model [32];

  always #5 clk = ~clk;

  pred_wb_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .result(result), .pred(pred), .ew_sel(ew_sel), .pred_inv(pred_inv),
    .zero_mode(zero_mode), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_data(wr_data), .byte_we(byte_we)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_mask(input logic [1:0] ew, input logic [7:0] p, input logic inv);
    logic [7:0] m;
    int span = 1 << ew;
    for (int b = 0; b < 8; b++) m[b] = p[b / span] ^ inv;
    return m;
  endfunction

  task automatic do_write(input logic [4:0] a, input logic [63:0] res, input logic [7:0] p,
                          input logic [1:0] ew, input logic inv, input logic zm,
                          input logic v, input string tag);
    logic [7:0]  m;
    logic [7:0]  exp_we;
    logic [63:0] exp_wd;
    @(negedge clk);
    wr_addr = a; result = res; pred = p; ew_sel = ew; pred_inv = inv;
    zero_mode = zm; wr_valid = v; rd_addr = a;
    m = ref_mask(ew, p, inv);
    exp_we = !v ? 8'h00 : (zm ? 8'hFF : m);
    for (int b = 0; b < 8; b++)
      exp_wd[b*8 +: 8] = (zm && !m[b]) ? 8'h00 : res[b*8 +: 8];
    #1;
    check(byte_we == exp_we, {tag, " strobes"}, {56'h0, byte_we}, {56'h0, exp_we});
    check(wr_data == exp_wd, {tag, " data"}, wr_data, exp_wd);
    for (int b = 0; b < 8; b++)
      if (exp_we[b]) model[a][b*8 +: 8] = exp_wd[b*8 +: 8];
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    check(rd_data == model[a], {tag, " readback"}, rd_data, model[a]);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 32; a += 7) begin
      rd_addr = 5'(a);
      #1;
      check(rd_data == 64'h0, "R7 reset entry", rd_data, 64'h0);
    end
    check(byte_we == 8'h00, "R5 idle after reset", {56'h0, byte_we}, 64'h0);
  endtask

  task automatic t_merge_widths;
    logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'h01, 8'hFE};
    for (int ew = 0; ew < 4; ew++) begin
      for (int k = 0; k < 4; k++) begin
        logic [4:0] a = 5'(ew * 4 + k);
        do_write(a, 64'h1122_3344_5566_7788 ^ {8{8'(a)}}, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b1, "R7 fill");
        do_write(a, 64'hDEAD_BEEF_CAFE_F00D, pats[k], 2'(ew), 1'b0, 1'b0, 1'b1, "R1 R3 merge");
      end
    end
  endtask

  task automatic t_invert;
    do_write(5'd20, 64'h0F0F_0F0F_0F0F_0F0F, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b1, "R7 fill");
    do_write(5'd20, 64'h9988_7766_5544_3322, 8'h5A, 2'b00, 1'b1, 1'b0, 1'b1, "R2 invert b8");
    do_write(5'd20, 64'h1357_9BDF_2468_ACE0, 8'h02, 2'b10, 1'b1, 1'b0, 1'b1, "R2 invert b32");
    do_write(5'd21, 64'hFFFF_0000_FFFF_0000, 8'h06, 2'b01, 1'b1, 1'b1, 1'b1, "R2 R4 invert zero");
  endtask

  task automatic t_zero;
    do_write(5'd22, 64'hAAAA_BBBB_CCCC_DDDD, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b1, "R7 fill");
    do_write(5'd22, 64'h0123_4567_89AB_CDEF, 8'h96, 2'b00, 1'b0, 1'b1, 1'b1, "R4 zero b8");
    do_write(5'd22, 64'h0123_4567_89AB_CDEF, 8'h01, 2'b10, 1'b0, 1'b1, 1'b1, "R4 zero b32");
    do_write(5'd22, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 2'b11, 1'b0, 1'b1, 1'b1, "R4 zero all");
  endtask

  task automatic t_idle;
    do_write(5'd23, 64'h7777_6666_5555_4444, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b1, "R7 fill");
    do_write(5'd23, 64'h0, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b0, "R5 idle merge");
    do_write(5'd23, 64'h0, 8'h00, 2'b11, 1'b0, 1'b1, 1'b0, "R5 idle zero");
  endtask

  task automatic t_upper;
    do_write(5'd24, 64'h5555_5555_5555_5555, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b1, "R7 fill");
    do_write(5'd24, 64'h1234_5678_9ABC_DEF0, 8'hFE, 2'b11, 1'b0, 1'b0, 1'b1, "R6 b64 upper set");
    do_write(5'd24, 64'h0FED_CBA9_8765_4321, 8'hF1, 2'b10, 1'b0, 1'b0, 1'b1, "R6 b32 upper set");
    do_write(5'd24, 64'hAAAA_5555_AAAA_5555, 8'h0A, 2'b10, 1'b0, 1'b1, 1'b1, "R6 R4 b32 zero");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 32; a++) model[a] = 64'h0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; result = '0; pred = '0;
    ew_sel = '0; pred_inv = 1'b0; zero_mode = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_merge_widths();
    t_invert();
    t_zero();
    t_idle();
    t_upper();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule